// File: doc/BRIEF.md
# Serial Bus Master Control and Interrupt Unit

This unit is the register-facing half of a two-wire serial bus master. A host on a simple single-cycle register bus loads a transfer description: command code, target runtime address, hardware device address, register address and write data. It then sets a start bit. The unit hands these fields to a separate frame engine. It holds the start bit high while the engine works, and it records how the transfer ended in a status word. A level interrupt is raised from that status word.

The same register space holds the bus clock divider and output delay, a device-mode initialisation word, and software overrides for the clock and data lines. The unit passes these settings to the rest of the master but does not act on them. The host can abort a transfer, which ends it quietly. It can also issue a soft reset, which returns every register to its reset value and pulses a reset to the engine.

Register writes take effect at the clock edge on which `reg_sel` and `reg_wr` are both high. Read data is combinational from the stored state and the address.

Top module: `sbm_ctl_unit`

## Requirements
- R1: After reset every register reads 0, `irq` is 0 and all engine-facing outputs are 0. The only exception is line-control bits 5:4, which show the live line levels.
- R2: Writing control offset 0x00 with bit 7 set, bits 6 and 0 clear, while idle sets the start bit. Control bit 7 then reads 1 until the transfer ends, and `eng_start` is high for exactly the one cycle after the write edge. Control bit 1 (global interrupt enable) takes the written bit 1 on every control write that has bit 0 clear.
- R3: `eng_done` while start is set clears start. If `eng_err` is 0, status bit 0 is set. If `eng_err` is 1, status bit 1 is set, bit 16 takes `eng_ack_err` and bits 11:8 take `eng_data_err`. `eng_done` while idle changes nothing.
- R4: A control write with bit 6 set clears start, pulses `eng_abort` for one cycle and sets no status flag. It wins over bit 7 in the same write, and a later `eng_done` is ignored.
- R5: A control write with bit 0 set makes control bit 0 read 1 and `eng_reset` high for one cycle. After that cycle every register is back at its reset value.
- R6: Status offset 0x0C is write-one-to-clear on bits 0, 1, 2, 11:8 and 16. Zeros leave bits unchanged. A hardware set in the same cycle wins over the clear.
- R7: `irq` is high exactly when control bit 1 is set and some status bit is set together with the same bit of the enable register at offset 0x08.
- R8: While start is set, writes to offsets 0x10, 0x1C, 0x2C or 0x30 leave those registers unchanged and set status bit 2. A control write with bit 7 set (bits 6 and 0 clear) while start is set also sets status bit 2.
- R9: Command (0x2C, bits 7:0), register address (0x10, bits 7:0), data (0x1C, 32 bits) and device address (0x30: runtime address in bits 23:16, hardware address in bits 15:0) read back as written and drive the matching engine outputs.
- R10: A successful `eng_done` with `eng_rdv` high loads `eng_rdata` into the data register.
- R11: Line control at 0x24 behaves as follows. Bit 0 enables the data-line override and bit 1 is its value. Bit 2 enables the clock-line override and bit 3 is its value. Bit 4 reads `sda_in` and bit 5 reads `scl_in`.
- R12: Clock offset 0x04 holds a divider in bits 7:0 and a delay in bits 10:8, both driven out. Device-mode offset 0x28 holds 32 bits, driven out on `dm_cfg`. Its bit 31 clears when `dm_done` is high and no write to 0x28 occurs in that cycle.
- R13: Unmapped offsets read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register access select |
| reg_wr | input | 1 | Write strobe (with reg_sel) |
| reg_addr | input | ADDR_W | Byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| eng_start | output | 1 | One-cycle transfer launch |
| eng_abort | output | 1 | One-cycle abort request |
| eng_reset | output | 1 | One-cycle engine reset |
| eng_done | input | 1 | Transfer finished |
| eng_err | input | 1 | Transfer ended in error |
| eng_ack_err | input | 1 | Acknowledge error seen |
| eng_data_err | input | 4 | Per-byte data errors |
| eng_rdv | input | 1 | eng_rdata holds read data |
| eng_rdata | input | 32 | Data read from the target |
| xfer_cmd | output | 8 | Command code |
| xfer_rta | output | 8 | Runtime address |
| xfer_hwa | output | 16 | Hardware device address |
| xfer_radr | output | 8 | Target register address |
| xfer_wdata | output | 32 | Write data |
| clk_div | output | 8 | Bus clock divider |
| sda_dly | output | 3 | Data output delay |
| dm_cfg | output | 32 | Device-mode word |
| dm_done | input | 1 | Device-mode sequence finished |
| sda_ovr_en | output | 1 | Data-line override enable |
| sda_ovr_val | output | 1 | Data-line override value |
| scl_ovr_en | output | 1 | Clock-line override enable |
| scl_ovr_val | output | 1 | Clock-line override value |
| sda_in | input | 1 | Live data-line level |
| scl_in | input | 1 | Live clock-line level |
| irq | output | 1 | Level interrupt |

## Verification
The assertions take three things for granted about the engine and the host. First, the engine raises `eng_done` for a single cycle. Second, its error qualifiers are only meaningful alongside `eng_done`. Third, the host never writes during the one cycle in which a soft reset is taking effect. The stimulus respects all three: every engine completion and host write is a one-cycle pulse driven on the falling edge, and the soft reset is issued only at the end, followed by an idle cycle. Random `eng_done` pulses are also sent while idle, on purpose, to exercise the ignore rule.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
  localparam int DATA_W  = 32;
  localparam int CMD_W   = 8;
  localparam int RTA_W   = 8;
  localparam int HWA_W   = 16;
  localparam int RADR_W  = 8;
  localparam int DERR_N  = 4;
  localparam int DIV_W   = 8;
  localparam int DLY_W   = 3;
  localparam int LINE_W  = 4;

  localparam logic [7:0] OFS_CTRL  = 8'h00;
  localparam logic [7:0] OFS_CLK   = 8'h04;
  localparam logic [7:0] OFS_IE    = 8'h08;
  localparam logic [7:0] OFS_STS   = 8'h0C;
  localparam logic [7:0] OFS_RADR  = 8'h10;
  localparam logic [7:0] OFS_DATA  = 8'h1C;
  localparam logic [7:0] OFS_LINE  = 8'h24;
  localparam logic [7:0] OFS_DMODE = 8'h28;
  localparam logic [7:0] OFS_CMD   = 8'h2C;
  localparam logic [7:0] OFS_DAR   = 8'h30;

  localparam int B_START = 7;
  localparam int B_ABORT = 6;
  localparam int B_GIE   = 1;
  localparam int B_SRST  = 0;

  localparam int B_DONE  = 0;
  localparam int B_ERR   = 1;
  localparam int B_LB    = 2;
  localparam int B_DERR  = 8;
  localparam int B_ACK   = 16;

  localparam logic [DATA_W-1:0] STS_MASK = 32'h0001_0F07;

  function automatic logic [DATA_W-1:0] w1c_next(input logic [DATA_W-1:0] cur,
                                                 input logic [DATA_W-1:0] clr,
                                                 input logic [DATA_W-1:0] set);
    return (cur & ~clr) | set;
  endfunction

  function automatic logic irq_level(input logic gie,
                                     input logic [DATA_W-1:0] sts,
                                     input logic [DATA_W-1:0] ie);
    return gie & (|(sts & ie & STS_MASK));
  endfunction
endpackage

// File: rtl/sbm_seq.sv
module sbm_seq
  import sbm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              eng_done,
  output logic              start_q,
  output logic              gie_q,
  output logic              srst_q,
  output logic              eng_start_q,
  output logic              eng_abort_q,
  output logic              abort_evt,
  output logic              fin_evt,
  output logic              restart_busy
);
  logic srst_req, start_evt, plain_wr;

  assign plain_wr     = ctl_we && !wdata[B_SRST] && !srst_q;
  assign srst_req     = ctl_we && wdata[B_SRST] && !srst_q;
  assign abort_evt    = plain_wr && wdata[B_ABORT];
  assign start_evt    = plain_wr && !wdata[B_ABORT] && wdata[B_START] && !start_q;
  assign restart_busy = plain_wr && !wdata[B_ABORT] && wdata[B_START] && start_q;
  assign fin_evt      = eng_done && start_q && !abort_evt && !srst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q     <= 1'b0;
      gie_q       <= 1'b0;
      srst_q      <= 1'b0;
      eng_start_q <= 1'b0;
      eng_abort_q <= 1'b0;
    end else if (srst_q) begin
      start_q     <= 1'b0;
      gie_q       <= 1'b0;
      srst_q      <= 1'b0;
      eng_start_q <= 1'b0;
      eng_abort_q <= 1'b0;
    end else begin
      srst_q      <= srst_req;
      eng_start_q <= start_evt;
      eng_abort_q <= abort_evt;
      if (plain_wr) gie_q <= wdata[B_GIE];
      if (abort_evt || fin_evt) start_q <= 1'b0;
      else if (start_evt)       start_q <= 1'b1;
    end
  end
endmodule

// File: rtl/sbm_stat.sv
module sbm_stat
  import sbm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              ie_we,
  input  logic              sts_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              gie,
  input  logic              fin_evt,
  input  logic              eng_err,
  input  logic              eng_ack_err,
  input  logic [DERR_N-1:0] eng_data_err,
  input  logic              lb_evt,
  output logic [DATA_W-1:0] sts_q,
  output logic [DATA_W-1:0] ie_q,
  output logic              irq
);
  logic [DATA_W-1:0] set_v, clr_v;

  always_comb begin
    set_v = '0;
    if (fin_evt) begin
      if (eng_err) begin
        set_v[B_ERR]             = 1'b1;
        set_v[B_ACK]             = eng_ack_err;
        set_v[B_DERR +: DERR_N]  = eng_data_err;
      end else begin
        set_v[B_DONE] = 1'b1;
      end
    end
    if (lb_evt) set_v[B_LB] = 1'b1;
    clr_v = sts_we ? (wdata & STS_MASK) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
      ie_q  <= '0;
    end else if (clr) begin
      sts_q <= '0;
      ie_q  <= '0;
    end else begin
      sts_q <= w1c_next(sts_q, clr_v, set_v);
      if (ie_we) ie_q <= wdata & STS_MASK;
    end
  end

  assign irq = irq_level(gie, sts_q, ie_q);
endmodule

// File: rtl/sbm_cfg.sv
module sbm_cfg
  import sbm_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              busy,
  input  logic              fin_evt,
  input  logic              eng_err,
  input  logic              eng_rdv,
  input  logic [DATA_W-1:0] eng_rdata,
  input  logic              dm_done,
  output logic [CMD_W-1:0]  cmd_q,
  output logic [RADR_W-1:0] radr_q,
  output logic [DATA_W-1:0] data_q,
  output logic [RTA_W-1:0]  rta_q,
  output logic [HWA_W-1:0]  hwa_q,
  output logic [LINE_W-1:0] line_q,
  output logic [DIV_W-1:0]  div_q,
  output logic [DLY_W-1:0]  dly_q,
  output logic [DATA_W-1:0] dm_q,
  output logic              lb_evt
);
  logic wr_cmd, wr_radr, wr_data, wr_dar, wr_line, wr_clk, wr_dm;

  assign wr_cmd  = we && (addr == ADDR_W'(OFS_CMD));
  assign wr_radr = we && (addr == ADDR_W'(OFS_RADR));
  assign wr_data = we && (addr == ADDR_W'(OFS_DATA));
  assign wr_dar  = we && (addr == ADDR_W'(OFS_DAR));
  assign wr_line = we && (addr == ADDR_W'(OFS_LINE));
  assign wr_clk  = we && (addr == ADDR_W'(OFS_CLK));
  assign wr_dm   = we && (addr == ADDR_W'(OFS_DMODE));
  assign lb_evt  = busy && (wr_cmd || wr_radr || wr_data || wr_dar);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0; radr_q <= '0; data_q <= '0; rta_q <= '0; hwa_q <= '0;
      line_q <= '0; div_q <= '0; dly_q <= '0; dm_q <= '0;
    end else if (clr) begin
      cmd_q <= '0; radr_q <= '0; data_q <= '0; rta_q <= '0; hwa_q <= '0;
      line_q <= '0; div_q <= '0; dly_q <= '0; dm_q <= '0;
    end else begin
      if (wr_cmd && !busy)  cmd_q  <= wdata[CMD_W-1:0];
      if (wr_radr && !busy) radr_q <= wdata[RADR_W-1:0];
      if (wr_dar && !busy) begin
        hwa_q <= wdata[HWA_W-1:0];
        rta_q <= wdata[HWA_W +: RTA_W];
      end
      if (fin_evt && !eng_err && eng_rdv) data_q <= eng_rdata;
      else if (wr_data && !busy)          data_q <= wdata;
      if (wr_line) line_q <= wdata[LINE_W-1:0];
      if (wr_clk) begin
        div_q <= wdata[DIV_W-1:0];
        dly_q <= wdata[DIV_W +: DLY_W];
      end
      if (wr_dm)        dm_q <= wdata;
      else if (dm_done) dm_q[DATA_W-1] <= 1'b0;
    end
  end
endmodule

// File: rtl/sbm_ctl_unit.sv
module sbm_ctl_unit
  import sbm_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_sel,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              eng_start,
  output logic              eng_abort,
  output logic              eng_reset,
  input  logic              eng_done,
  input  logic              eng_err,
  input  logic              eng_ack_err,
  input  logic [3:0]        eng_data_err,
  input  logic              eng_rdv,
  input  logic [31:0]       eng_rdata,
  output logic [7:0]        xfer_cmd,
  output logic [7:0]        xfer_rta,
  output logic [15:0]       xfer_hwa,
  output logic [7:0]        xfer_radr,
  output logic [31:0]       xfer_wdata,
  output logic [7:0]        clk_div,
  output logic [2:0]        sda_dly,
  output logic [31:0]       dm_cfg,
  input  logic              dm_done,
  output logic              sda_ovr_en,
  output logic              sda_ovr_val,
  output logic              scl_ovr_en,
  output logic              scl_ovr_val,
  input  logic              sda_in,
  input  logic              scl_in,
  output logic              irq
);
  logic              we, ctl_we, ie_we, sts_we;
  logic              start_q, gie_q, srst_q, abort_evt, fin_evt, restart_busy;
  logic              cfg_lb, lb_evt;
  logic [DATA_W-1:0] sts_q, ie_q;
  logic [LINE_W-1:0] line_q;

  assign we     = reg_sel && reg_wr;
  assign ctl_we = we && (reg_addr == ADDR_W'(OFS_CTRL));
  assign ie_we  = we && (reg_addr == ADDR_W'(OFS_IE));
  assign sts_we = we && (reg_addr == ADDR_W'(OFS_STS));
  assign lb_evt = cfg_lb || restart_busy;

  sbm_seq u_seq (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .wdata(reg_wdata), .eng_done(eng_done),
    .start_q(start_q), .gie_q(gie_q), .srst_q(srst_q), .eng_start_q(eng_start),
    .eng_abort_q(eng_abort), .abort_evt(abort_evt), .fin_evt(fin_evt),
    .restart_busy(restart_busy)
  );

  sbm_stat u_stat (
    .clk(clk), .rst_n(rst_n), .clr(srst_q), .ie_we(ie_we), .sts_we(sts_we),
    .wdata(reg_wdata), .gie(gie_q), .fin_evt(fin_evt), .eng_err(eng_err),
    .eng_ack_err(eng_ack_err), .eng_data_err(eng_data_err), .lb_evt(lb_evt),
    .sts_q(sts_q), .ie_q(ie_q), .irq(irq)
  );

  sbm_cfg #(.ADDR_W(ADDR_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .clr(srst_q), .we(we), .addr(reg_addr), .wdata(reg_wdata),
    .busy(start_q), .fin_evt(fin_evt), .eng_err(eng_err), .eng_rdv(eng_rdv),
    .eng_rdata(eng_rdata), .dm_done(dm_done), .cmd_q(xfer_cmd), .radr_q(xfer_radr),
    .data_q(xfer_wdata), .rta_q(xfer_rta), .hwa_q(xfer_hwa), .line_q(line_q),
    .div_q(clk_div), .dly_q(sda_dly), .dm_q(dm_cfg), .lb_evt(cfg_lb)
  );

  assign eng_reset   = srst_q;
  assign sda_ovr_en  = line_q[0];
  assign sda_ovr_val = line_q[1];
  assign scl_ovr_en  = line_q[2];
  assign scl_ovr_val = line_q[3];

  always_comb begin
    reg_rdata = '0;
    if      (reg_addr == ADDR_W'(OFS_CTRL))  reg_rdata = {24'h0, start_q, 5'b0, gie_q, srst_q};
    else if (reg_addr == ADDR_W'(OFS_CLK))   reg_rdata = {21'h0, sda_dly, clk_div};
    else if (reg_addr == ADDR_W'(OFS_IE))    reg_rdata = ie_q;
    else if (reg_addr == ADDR_W'(OFS_STS))   reg_rdata = sts_q;
    else if (reg_addr == ADDR_W'(OFS_RADR))  reg_rdata = {24'h0, xfer_radr};
    else if (reg_addr == ADDR_W'(OFS_DATA))  reg_rdata = xfer_wdata;
    else if (reg_addr == ADDR_W'(OFS_LINE))  reg_rdata = {26'h0, scl_in, sda_in, line_q};
    else if (reg_addr == ADDR_W'(OFS_DMODE)) reg_rdata = dm_cfg;
    else if (reg_addr == ADDR_W'(OFS_CMD))   reg_rdata = {24'h0, xfer_cmd};
    else if (reg_addr == ADDR_W'(OFS_DAR))   reg_rdata = {8'h0, xfer_rta, xfer_hwa};
  end
endmodule

// File: rtl/sbm_ctl_chk.sv
module sbm_ctl_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_q,
  input logic              srst_q,
  input logic              gie_q,
  input logic              abort_evt,
  input logic              fin_evt,
  input logic              lb_evt,
  input logic              eng_start,
  input logic              eng_abort,
  input logic              irq,
  input logic [31:0]       sts_q,
  input logic              reg_sel,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [7:0]        xfer_cmd
);
  // R2: the launch pulse only ever appears with the start bit held
  a_r2_launch_held: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> start_q);
  // R2: start stays set until completion, abort or soft reset
  a_r2_start_hold: assert property (@(posedge clk) disable iff (!rst_n)
    start_q && !fin_evt && !abort_evt && !srst_q |=> start_q);
  // R3: an accepted completion ends the transfer and leaves a flag
  a_r3_fin_flag: assert property (@(posedge clk) disable iff (!rst_n)
    fin_evt |=> !start_q && (sts_q[0] || sts_q[1]));
  // R4: abort ends the transfer with a pulse and no new flag
  a_r4_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> !start_q && eng_abort && !$rose(sts_q[0]) && !$rose(sts_q[1]));
  // R5: soft reset lasts one cycle and clears state
  a_r5_srst_clear: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |=> !srst_q && !start_q && (sts_q == 32'h0));
  // R6, R8: load-busy event lands in status bit 2
  a_r8_lb_flag: assert property (@(posedge clk) disable iff (!rst_n)
    lb_evt && !srst_q |=> sts_q[2]);
  // R8: command register is frozen while busy
  a_r8_cmd_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    reg_sel && reg_wr && (reg_addr == ADDR_W'(8'h2C)) && start_q && !srst_q
    |=> $stable(xfer_cmd));
  // R7: no interrupt without the global enable
  a_r7_gie_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !gie_q |-> !irq);
endmodule

bind sbm_ctl_unit sbm_ctl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_q(start_q), .srst_q(srst_q), .gie_q(gie_q),
  .abort_evt(abort_evt), .fin_evt(fin_evt), .lb_evt(lb_evt), .eng_start(eng_start),
  .eng_abort(eng_abort), .irq(irq), .sts_q(sts_q), .reg_sel(reg_sel), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .xfer_cmd(xfer_cmd)
);

// File: tb/sbm_ctl_unit_tb_top.sv
module sbm_ctl_unit_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_sel = 0, reg_wr = 0;
  logic [7:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic eng_start, eng_abort, eng_reset;
  logic eng_done = 0, eng_err = 0, eng_ack_err = 0, eng_rdv = 0;
  logic [3:0] eng_data_err = 0;
  logic [31:0] eng_rdata = 0;
  logic [7:0] xfer_cmd, xfer_rta, xfer_radr, clk_div;
  logic [15:0] xfer_hwa;
  logic [31:0] xfer_wdata, dm_cfg;
  logic [2:0] sda_dly;
  logic dm_done = 0, sda_ovr_en, sda_ovr_val, scl_ovr_en, scl_ovr_val;
  logic sda_in = 0, scl_in = 0, irq;

  int checks = 0, errors = 0;

  // bench-side expected state
  logic m_start, m_gie;
  logic [31:0] m_sts, m_ie, m_data, m_dm;
  logic [7:0] m_cmd, m_radr, m_div;
  logic [23:0] m_dar;
  logic [3:0] m_line;
  logic [2:0] m_dly;

  localparam logic [31:0] SMASK = 32'h0001_0F07;

  always #2 clk = ~clk;

  sbm_ctl_unit dut_i (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_start(eng_start),
    .eng_abort(eng_abort), .eng_reset(eng_reset), .eng_done(eng_done), .eng_err(eng_err),
    .eng_ack_err(eng_ack_err), .eng_data_err(eng_data_err), .eng_rdv(eng_rdv),
    .eng_rdata(eng_rdata), .xfer_cmd(xfer_cmd), .xfer_rta(xfer_rta), .xfer_hwa(xfer_hwa),
    .xfer_radr(xfer_radr), .xfer_wdata(xfer_wdata), .clk_div(clk_div), .sda_dly(sda_dly),
    .dm_cfg(dm_cfg), .dm_done(dm_done), .sda_ovr_en(sda_ovr_en), .sda_ovr_val(sda_ovr_val),
    .scl_ovr_en(scl_ovr_en), .scl_ovr_val(scl_ovr_val), .sda_in(sda_in), .scl_in(scl_in),
    .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    m_start = 0; m_gie = 0; m_sts = 0; m_ie = 0; m_data = 0; m_dm = 0;
    m_cmd = 0; m_radr = 0; m_div = 0; m_dar = 0; m_line = 0; m_dly = 0;
  endtask

  function automatic logic [31:0] exp_rd(input logic [7:0] ofs);
    case (ofs)
      8'h00: return {24'h0, m_start, 5'b0, m_gie, 1'b0};
      8'h04: return {21'h0, m_dly, m_div};
      8'h08: return m_ie;
      8'h0C: return m_sts;
      8'h10: return {24'h0, m_radr};
      8'h1C: return m_data;
      8'h24: return {26'h0, scl_in, sda_in, m_line};
      8'h28: return m_dm;
      8'h2C: return {24'h0, m_cmd};
      8'h30: return {8'h0, m_dar};
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic exp_irq();
    return m_gie && (|(m_sts & m_ie));
  endfunction

  task automatic check_all(input string tag);
    logic [7:0] ofs_list[12] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h1C,
                                 8'h24, 8'h28, 8'h2C, 8'h30, 8'h14, 8'h3C};
    for (int i = 0; i < 12; i++) begin
      reg_addr = ofs_list[i];
      #1;
      chk($sformatf("%s rd@%h", tag, ofs_list[i]), reg_rdata, exp_rd(ofs_list[i]));
    end
    chk({tag, " R7 irq"}, {31'h0, irq}, {31'h0, exp_irq()});
    chk({tag, " R9 xfer outputs"}, {xfer_cmd, xfer_radr, xfer_rta, 8'h0},
        {m_cmd, m_radr, m_dar[23:16], 8'h0});
    chk({tag, " R9 hwa/data"}, {16'h0, xfer_hwa} ^ xfer_wdata, {16'h0, m_dar[15:0]} ^ m_data);
  endtask

  // one-cycle host write; returns at the falling edge after the write edge
  task automatic host_write(input logic [7:0] ofs, input logic [31:0] val);
    @(negedge clk);
    reg_sel = 1; reg_wr = 1; reg_addr = ofs; reg_wdata = val;
    @(negedge clk);
    reg_sel = 0; reg_wr = 0;
    case (ofs)
      8'h00: begin
        if (val[6]) m_start = 0;
        else if (val[7]) begin
          if (m_start) m_sts[2] = 1; else m_start = 1;
        end
        m_gie = val[1];
      end
      8'h04: begin m_div = val[7:0]; m_dly = val[10:8]; end
      8'h08: m_ie = val & SMASK;
      8'h0C: m_sts = m_sts & ~(val & SMASK);
      8'h10: if (m_start) m_sts[2] = 1; else m_radr = val[7:0];
      8'h1C: if (m_start) m_sts[2] = 1; else m_data = val;
      8'h2C: if (m_start) m_sts[2] = 1; else m_cmd = val[7:0];
      8'h30: if (m_start) m_sts[2] = 1; else m_dar = val[23:0];
      8'h24: m_line = val[3:0];
      8'h28: m_dm = val;
      default: ;
    endcase
  endtask

  task automatic eng_finish(input logic err, input logic ack, input logic [3:0] derr,
                            input logic rdv, input logic [31:0] rd);
    @(negedge clk);
    eng_done = 1; eng_err = err; eng_ack_err = ack; eng_data_err = derr;
    eng_rdv = rdv; eng_rdata = rd;
    @(negedge clk);
    eng_done = 0; eng_err = 0; eng_ack_err = 0; eng_data_err = 0; eng_rdv = 0;
    if (m_start) begin
      m_start = 0;
      if (err) m_sts = m_sts | 32'h2 | ({31'h0, ack} << 16) | ({28'h0, derr} << 8);
      else begin
        m_sts[0] = 1;
        if (rdv) m_data = rd;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired (all requirements)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check_all("R1 reset");
    chk("R1 engine pulses", {29'h0, eng_start, eng_abort, eng_reset}, 32'h0);

    // R9 transfer registers
    host_write(8'h2C, 32'hFFFF_FF8B);
    host_write(8'h10, 32'h0000_0133);
    host_write(8'h1C, 32'hDEAD_BEEF);
    host_write(8'h30, 32'hAB2D_03A3);
    check_all("R9 load");

    // R12 clock and device mode
    host_write(8'h04, 32'hFFFF_FFFF);
    chk("R12 clk outputs", {21'h0, sda_dly, clk_div}, 32'h0000_07FF);
    host_write(8'h28, 32'h807C_3E00);
    chk("R12 dm_cfg", dm_cfg, 32'h807C_3E00);
    @(negedge clk); dm_done = 1;
    @(negedge clk); dm_done = 0; m_dm[31] = 0;
    chk("R12 dm bit31 cleared", dm_cfg, 32'h007C_3E00);

    // R11 line control
    host_write(8'h24, 32'h0000_000A);
    chk("R11 overrides", {28'h0, scl_ovr_val, scl_ovr_en, sda_ovr_val, sda_ovr_en}, 32'hA);
    sda_in = 1; scl_in = 0;
    check_all("R11 live sda");
    sda_in = 0; scl_in = 1;
    check_all("R11 live scl");

    // R2 start
    host_write(8'h08, SMASK);
    host_write(8'h00, 32'h0000_0082);
    chk("R2 eng_start pulse", {31'h0, eng_start}, 32'h1);
    @(negedge clk);
    chk("R2 eng_start one cycle", {31'h0, eng_start}, 32'h0);
    repeat (3) @(negedge clk);
    check_all("R2 start held");

    // R8 protected writes while busy
    host_write(8'h2C, 32'h0000_004E);
    host_write(8'h30, 32'h0000_0745);
    host_write(8'h00, 32'h0000_0082);
    check_all("R8 load-busy");

    // R3 + R10 successful read completion
    eng_finish(0, 0, 4'h0, 1, 32'h0000_00C5);
    check_all("R3 R10 done");

    // R6 write-one-to-clear
    host_write(8'h0C, 32'h0000_0004);
    check_all("R6 clear lb only");
    host_write(8'h0C, 32'hFFFF_FFFF);
    check_all("R6 clear all");

    // R3 error completion
    host_write(8'h00, 32'h0000_0082);
    eng_finish(1, 1, 4'h5, 1, 32'h1111_1111);
    check_all("R3 error fields");
    host_write(8'h0C, 32'hFFFF_FFFF);

    // R4 abort with start in the same write, then late done
    host_write(8'h00, 32'h0000_0082);
    host_write(8'h00, 32'h0000_00C2);
    chk("R4 eng_abort pulse", {31'h0, eng_abort}, 32'h1);
    eng_finish(0, 0, 4'h0, 1, 32'h2222_2222);
    check_all("R4 abort quiet");

    // R7 gate by global enable
    host_write(8'h00, 32'h0000_0080);
    eng_finish(0, 0, 4'h0, 0, 32'h0);
    check_all("R7 gie off");
    host_write(8'h00, 32'h0000_0002);
    check_all("R7 gie on");

    // R13 unmapped
    host_write(8'h14, 32'hFFFF_FFFF);
    host_write(8'h3C, 32'hFFFF_FFFF);
    check_all("R13 unmapped");

    // random mix
    for (int it = 0; it < 400; it++) begin
      int op;
      op = $urandom_range(0, 7);
      case (op)
        0, 1: begin
          logic [7:0] xo[4] = '{8'h10, 8'h1C, 8'h2C, 8'h30};
          host_write(xo[$urandom_range(0, 3)], $urandom);
        end
        2: host_write(8'h00, 32'h80 | ({31'h0, 1'($urandom)} << 1));
        3: host_write(8'h00, 32'h40 | ({31'h0, 1'($urandom)} << 7) | ({31'h0, 1'($urandom)} << 1));
        4: eng_finish(1'($urandom), 1'($urandom), 4'($urandom), 1'($urandom), $urandom);
        5: host_write(8'h0C, $urandom);
        6: host_write(8'h08, $urandom);
        default: host_write(($urandom & 1) ? 8'h24 : 8'h04, $urandom);
      endcase
      check_all($sformatf("R3 R6 R8 random %0d", it));
    end

    // R5 soft reset
    host_write(8'h00, 32'h0000_0001);
    chk("R5 eng_reset pulse", {31'h0, eng_reset}, 32'h1);
    reg_addr = 8'h00; #1;
    chk("R5 srst reads 1", reg_rdata & 32'h1, 32'h1);
    @(negedge clk);
    model_clear();
    check_all("R5 after soft reset");
    chk("R5 eng_reset ends", {31'h0, eng_reset}, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule